// File: doc/BRIEF.md
# Bus Controller Reply Validator

This block judges the reply that a remote terminal sends after the bus controller has issued a command. A word decoder outside the block presents each received word with a strobe and a set of flags: sync kind, parity result, encoding result, a gap marker and 16 data bits. The decoder also pulses a separate line when no word arrives within the allowed response time. At the start of each message the controller gives the block three things: the command kind, the number of data words it expects, and the terminal addresses involved.

The block walks through the reply in the order the command kind dictates. It stores status words in two capture registers and forwards good data words to a receive store through a one-cycle push strobe. Every message ends in exactly one of two outcomes, valid or error. On an error, cause bits in a sticky register say what went wrong. After the last expected word the block waits through a short quiet window before it declares the message valid, so that a trailing extra word is caught. An extra word that arrives even after the valid flag has been raised still turns the outcome into an error.

Top module: `bc_reply_check`

## Requirements
- R1: After reset, msg_valid, msg_error, rx_push and busy are low, and err_bits, stat1 and stat2 are zero.
- R2: A start pulse clears msg_valid, msg_error and err_bits on the next edge and raises busy. msg_valid and msg_error are never high together, and every completed message ends with exactly one of them high.
- R3: The cmd_kind encoding is 0 = status only, 1 = status followed by exp_words data words, and 2 = terminal-to-terminal. Kind 2 expects the transmitting terminal's status, then exp_words data words, then the receiving terminal's status. A faultless status word is stored in stat1, except the first status of kind 2, which is stored in stat2. The capture registers change only on an accepted status word.
- R4: Each faultless data word in the expected sequence appears on rx_data with rx_push high for one cycle, on the edge after it is accepted. Faulty words and extra words are never pushed.
- R5: A word is faulty when any of these hold. Its sync kind does not match what is expected: wd_is_cmd=1 is expected for a status word and 0 for a data word (err bit 1). Its encoding flag is low (bit 2). Its parity flag is low (bit 3). Its gap marker is high (bit 6). A faulty word ends the message with msg_error, and every cause bit that applies is set.
- R6: A status word with correct sync, encoding and parity is checked for address. Its bits 15:11 must equal rt_addr, or tx_rt_addr for the first status of kind 2. A mismatch sets err bit 5 and ends in error.
- R7: resp_timeout while a status word is awaited sets err bit 0. While a data word is awaited it sets err bit 4 (too few words). Either case ends in error.
- R8: After the last expected word is accepted, msg_valid rises on the QUIET_CYC-th following edge with err_bits zero. A word that arrives inside that window sets err bit 4 and ends in error.
- R9: A word that arrives while msg_valid is high clears msg_valid and sets msg_error and err bit 4 on the next edge.
- R10: Words that arrive while idle, or after an error outcome, leave msg_valid, msg_error, err_bits and the capture registers unchanged and are not pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin checking a new reply; latches the command fields |
| cmd_kind | input | 2 | 0 status only, 1 status plus data, 2 terminal-to-terminal |
| exp_words | input | CNT_W | Number of data words expected |
| rt_addr | input | AW | Address of the responding (receiving) terminal |
| tx_rt_addr | input | AW | Address of the transmitting terminal for kind 2 |
| wd_valid | input | 1 | One-cycle strobe for a decoded word |
| wd_is_cmd | input | 1 | 1 = command/status sync, 0 = data sync |
| wd_par_ok | input | 1 | Parity check passed |
| wd_enc_ok | input | 1 | Bit encoding check passed |
| wd_gap | input | 1 | Word was not contiguous with the previous word |
| wd_data | input | DW | Decoded word contents |
| resp_timeout | input | 1 | Pulse: no word arrived within the response time |
| msg_valid | output | 1 | Message judged valid |
| msg_error | output | 1 | Message judged in error |
| err_bits | output | 7 | Sticky cause bits, indices as in R5 to R8 |
| stat1 | output | DW | Status of the responding or receiving terminal |
| stat2 | output | DW | Status of the transmitting terminal for kind 2 |
| rx_push | output | 1 | Push strobe to the receive store |
| rx_data | output | DW | Data word for the receive store |
| busy | output | 1 | A reply is being checked |

## Verification
The assertions assume that wd_valid is a single-cycle strobe whose flags are valid in the same cycle. They also assume that start is never raised while a word strobe is meant for the reply being checked, and that resp_timeout is not pulsed together with a word. The bench drives all inputs one time step after a rising edge and holds each strobe for exactly one cycle. It keeps start, words and timeouts in separate cycles and keeps exp_words inside 1 to MAX_WORDS. Extra words are injected only after the full sequence has been sent, so the quiet-window rule and the late-word rule are each exercised without overlapping another fault.

// File: rtl/bcrc_pkg.sv
package bcrc_pkg;
   localparam int ERR_W    = 7;
   localparam int E_NORESP = 0;
   localparam int E_SYNC   = 1;
   localparam int E_ENC    = 2;
   localparam int E_PAR    = 3;
   localparam int E_COUNT  = 4;
   localparam int E_ADDR   = 5;
   localparam int E_GAP    = 6;

   typedef enum logic [1:0] {
      KIND_STAT  = 2'd0,
      KIND_DATA  = 2'd1,
      KIND_T2T   = 2'd2,
      KIND_RSVD  = 2'd3
   } kind_e;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_STAT_FIRST = 3'd1,
      ST_DATA       = 3'd2,
      ST_STAT_LAST  = 3'd3,
      ST_QUIET      = 3'd4,
      ST_DONE       = 3'd5
   } state_e;
endpackage

// File: rtl/bcrc_word_check.sv
module bcrc_word_check
   import bcrc_pkg::*;
#(
   parameter int AW         = 5,
   parameter bit ADDR_CHECK = 1'b1
) (
   input  logic             want_status,
   input  logic [AW-1:0]    exp_addr,
   input  logic [AW-1:0]    word_addr,
   input  logic             is_cmd,
   input  logic             par_ok,
   input  logic             enc_ok,
   input  logic             gap,
   output logic [ERR_W-1:0] werr
);
   logic addr_bad;

   generate
      if (ADDR_CHECK) begin : g_addr
         assign addr_bad = want_status && is_cmd && par_ok && enc_ok &&
                           (word_addr != exp_addr);
      end else begin : g_no_addr
         assign addr_bad = 1'b0;
      end
   endgenerate

   always_comb begin
      werr           = '0;
      werr[E_SYNC]   = (is_cmd != want_status);
      werr[E_ENC]    = !enc_ok;
      werr[E_PAR]    = !par_ok;
      werr[E_GAP]    = gap;
      werr[E_ADDR]   = addr_bad;
   end
endmodule

// File: rtl/bcrc_quiet_timer.sv
module bcrc_quiet_timer #(
   parameter int QUIET_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   generate
      if (QUIET_CYC <= 1) begin : g_short
         assign expired = run;
      end else begin : g_count
         localparam int TW = $clog2(QUIET_CYC);
         logic [TW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign expired = run && (cnt_q == TW'(QUIET_CYC - 1));
      end
   endgenerate
endmodule

// File: rtl/bc_reply_check.sv
module bc_reply_check
   import bcrc_pkg::*;
#(
   parameter int DW         = 16,
   parameter int AW         = 5,
   parameter int MAX_WORDS  = 32,
   parameter int CNT_W      = $clog2(MAX_WORDS + 1),
   parameter int QUIET_CYC  = 8,
   parameter bit ADDR_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       cmd_kind,
   input  logic [CNT_W-1:0] exp_words,
   input  logic [AW-1:0]    rt_addr,
   input  logic [AW-1:0]    tx_rt_addr,
   input  logic             wd_valid,
   input  logic             wd_is_cmd,
   input  logic             wd_par_ok,
   input  logic             wd_enc_ok,
   input  logic             wd_gap,
   input  logic [DW-1:0]    wd_data,
   input  logic             resp_timeout,
   output logic             msg_valid,
   output logic             msg_error,
   output logic [6:0]       err_bits,
   output logic [DW-1:0]    stat1,
   output logic [DW-1:0]    stat2,
   output logic             rx_push,
   output logic [DW-1:0]    rx_data,
   output logic             busy
);
   generate
      if (DW < AW + 1) begin : g_bad_width
         initial $fatal(1, "word width too small for address field");
      end
      if (CNT_W < $clog2(MAX_WORDS + 1)) begin : g_bad_count
         initial $fatal(1, "count width too small for MAX_WORDS");
      end
      if (ERR_W != 7) begin : g_bad_err
         initial $fatal(1, "cause register width mismatch");
      end
   endgenerate

   state_e           state_q;
   kind_e            kind_q;
   logic [CNT_W-1:0] need_q;
   logic [CNT_W-1:0] cnt_q;
   logic [AW-1:0]    addr_q;
   logic [AW-1:0]    txaddr_q;

   logic             want_status;
   logic [AW-1:0]    exp_addr;
   logic [ERR_W-1:0] werr;
   logic             word_bad;
   logic             quiet_done;
   logic [CNT_W-1:0] cnt_next;

   assign want_status = (state_q == ST_STAT_FIRST) || (state_q == ST_STAT_LAST);
   assign exp_addr    = ((state_q == ST_STAT_FIRST) && (kind_q == KIND_T2T)) ?
                        txaddr_q : addr_q;
   assign word_bad    = |werr;
   assign cnt_next    = cnt_q + 1'b1;

   bcrc_word_check #(
      .AW         (AW),
      .ADDR_CHECK (ADDR_CHECK)
   ) u_word (
      .want_status (want_status),
      .exp_addr    (exp_addr),
      .word_addr   (wd_data[DW-1 -: AW]),
      .is_cmd      (wd_is_cmd),
      .par_ok      (wd_par_ok),
      .enc_ok      (wd_enc_ok),
      .gap         (wd_gap),
      .werr        (werr)
   );

   bcrc_quiet_timer #(
      .QUIET_CYC (QUIET_CYC)
   ) u_quiet (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_QUIET),
      .expired (quiet_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         kind_q    <= KIND_STAT;
         need_q    <= '0;
         cnt_q     <= '0;
         addr_q    <= '0;
         txaddr_q  <= '0;
         msg_valid <= 1'b0;
         msg_error <= 1'b0;
         err_bits  <= '0;
         stat1     <= '0;
         stat2     <= '0;
         rx_push   <= 1'b0;
         rx_data   <= '0;
      end else begin
         rx_push <= 1'b0;
         if (start) begin
            state_q   <= ST_STAT_FIRST;
            kind_q    <= kind_e'(cmd_kind);
            need_q    <= exp_words;
            cnt_q     <= '0;
            addr_q    <= rt_addr;
            txaddr_q  <= tx_rt_addr;
            msg_valid <= 1'b0;
            msg_error <= 1'b0;
            err_bits  <= '0;
         end else begin
            case (state_q)
               ST_STAT_FIRST, ST_STAT_LAST: begin
                  if (wd_valid) begin
                     if (word_bad) begin
                        err_bits  <= err_bits | werr;
                        msg_error <= 1'b1;
                        state_q   <= ST_DONE;
                     end else if (state_q == ST_STAT_LAST) begin
                        stat1   <= wd_data;
                        state_q <= ST_QUIET;
                     end else begin
                        if (kind_q == KIND_T2T) begin
                           stat2 <= wd_data;
                        end else begin
                           stat1 <= wd_data;
                        end
                        cnt_q <= '0;
                        if (kind_q == KIND_DATA || kind_q == KIND_T2T) begin
                           if (need_q != '0) begin
                              state_q <= ST_DATA;
                           end else if (kind_q == KIND_T2T) begin
                              state_q <= ST_STAT_LAST;
                           end else begin
                              state_q <= ST_QUIET;
                           end
                        end else begin
                           state_q <= ST_QUIET;
                        end
                     end
                  end else if (resp_timeout) begin
                     err_bits[E_NORESP] <= 1'b1;
                     msg_error          <= 1'b1;
                     state_q            <= ST_DONE;
                  end
               end
               ST_DATA: begin
                  if (wd_valid) begin
                     if (word_bad) begin
                        err_bits  <= err_bits | werr;
                        msg_error <= 1'b1;
                        state_q   <= ST_DONE;
                     end else begin
                        rx_push <= 1'b1;
                        rx_data <= wd_data;
                        cnt_q   <= cnt_next;
                        if (cnt_next == need_q) begin
                           state_q <= (kind_q == KIND_T2T) ? ST_STAT_LAST : ST_QUIET;
                        end
                     end
                  end else if (resp_timeout) begin
                     err_bits[E_COUNT] <= 1'b1;
                     msg_error         <= 1'b1;
                     state_q           <= ST_DONE;
                  end
               end
               ST_QUIET: begin
                  if (wd_valid) begin
                     err_bits[E_COUNT] <= 1'b1;
                     msg_error         <= 1'b1;
                     state_q           <= ST_DONE;
                  end else if (quiet_done) begin
                     msg_valid <= 1'b1;
                     state_q   <= ST_DONE;
                  end
               end
               ST_DONE: begin
                  if (wd_valid && msg_valid) begin
                     msg_valid         <= 1'b0;
                     msg_error         <= 1'b1;
                     err_bits[E_COUNT] <= 1'b1;
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

   assign busy = (state_q != ST_IDLE) && (state_q != ST_DONE);
endmodule

// File: rtl/bcrc_chk.sv
module bcrc_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          wd_valid,
   input logic          wd_is_cmd,
   input logic          wd_par_ok,
   input logic          wd_enc_ok,
   input logic          wd_gap,
   input logic [DW-1:0] wd_data,
   input logic          msg_valid,
   input logic          msg_error,
   input logic [6:0]    err_bits,
   input logic [DW-1:0] stat1,
   input logic [DW-1:0] stat2,
   input logic          rx_push,
   input logic [DW-1:0] rx_data
);
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(msg_valid && msg_error)); // R2

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!msg_valid && !msg_error && err_bits == 7'd0)); // R2

   AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wd_valid) |-> ($stable(stat1) && $stable(stat2))); // R3

   AST_PUSH_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> $past(wd_valid && wd_enc_ok && wd_par_ok && !wd_is_cmd && !wd_gap)); // R4

   AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (rx_data == $past(wd_data))); // R4

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_error |-> (err_bits != 7'd0)); // R5

   AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (err_bits == 7'd0)); // R8

   AST_LATE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && wd_valid && !start) |=> (msg_error && !msg_valid && err_bits[4])); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_error && !start) |=> (msg_error && $stable(err_bits))); // R10
endmodule

bind bc_reply_check bcrc_chk #(.DW(DW)) u_bcrc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .wd_valid  (wd_valid),
   .wd_is_cmd (wd_is_cmd),
   .wd_par_ok (wd_par_ok),
   .wd_enc_ok (wd_enc_ok),
   .wd_gap    (wd_gap),
   .wd_data   (wd_data),
   .msg_valid (msg_valid),
   .msg_error (msg_error),
   .err_bits  (err_bits),
   .stat1     (stat1),
   .stat2     (stat2),
   .rx_push   (rx_push),
   .rx_data   (rx_data)
);

// File: tb/test_bc_reply_check.sv
`timescale 1ns/1ps
module test_bc_reply_check;
   localparam int Q  = 8;
   localparam int NV = 16;

   // row: kind[23:22] count[21:16] fault[15:13] fpos[12:7] err[6:0]
   // fault: 0 none 1 sync 2 enc 3 par 4 addr 5 gap 6 timeout 7 extra
   localparam logic [23:0] VEC [0:NV-1] = '{
      {2'd0, 6'd0,  3'd0, 6'd0, 7'h00},
      {2'd1, 6'd4,  3'd0, 6'd0, 7'h00},
      {2'd2, 6'd3,  3'd0, 6'd0, 7'h00},
      {2'd1, 6'd4,  3'd7, 6'd0, 7'h10},
      {2'd1, 6'd3,  3'd3, 6'd2, 7'h08},
      {2'd1, 6'd3,  3'd2, 6'd0, 7'h04},
      {2'd0, 6'd0,  3'd1, 6'd0, 7'h02},
      {2'd2, 6'd2,  3'd4, 6'd0, 7'h20},
      {2'd2, 6'd2,  3'd4, 6'd3, 7'h20},
      {2'd1, 6'd5,  3'd5, 6'd3, 7'h40},
      {2'd1, 6'd4,  3'd6, 6'd0, 7'h01},
      {2'd1, 6'd4,  3'd6, 6'd2, 7'h10},
      {2'd2, 6'd2,  3'd6, 6'd3, 7'h01},
      {2'd1, 6'd32, 3'd0, 6'd0, 7'h00},
      {2'd1, 6'd1,  3'd1, 6'd1, 7'h02},
      {2'd2, 6'd1,  3'd7, 6'd0, 7'h10}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  cmd_kind = '0;
   logic [5:0]  exp_words = '0;
   logic [4:0]  rt_addr = '0;
   logic [4:0]  tx_rt_addr = '0;
   logic        wd_valid = 1'b0;
   logic        wd_is_cmd = 1'b0;
   logic        wd_par_ok = 1'b1;
   logic        wd_enc_ok = 1'b1;
   logic        wd_gap = 1'b0;
   logic [15:0] wd_data = '0;
   logic        resp_timeout = 1'b0;
   logic        msg_valid, msg_error, rx_push, busy;
   logic [6:0]  err_bits;
   logic [15:0] stat1, stat2, rx_data;

   int nchk = 0;
   int nfail = 0;
   int push_n = 0;
   logic [15:0] push_log [0:63];
   bit finished = 1'b0;

   always #5 clk = ~clk;

   bc_reply_check #(.QUIET_CYC(Q)) i_bc_reply_check (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_kind(cmd_kind),
      .exp_words(exp_words), .rt_addr(rt_addr), .tx_rt_addr(tx_rt_addr),
      .wd_valid(wd_valid), .wd_is_cmd(wd_is_cmd), .wd_par_ok(wd_par_ok),
      .wd_enc_ok(wd_enc_ok), .wd_gap(wd_gap), .wd_data(wd_data),
      .resp_timeout(resp_timeout), .msg_valid(msg_valid), .msg_error(msg_error),
      .err_bits(err_bits), .stat1(stat1), .stat2(stat2), .rx_push(rx_push),
      .rx_data(rx_data), .busy(busy)
   );

   always @(negedge clk) begin
      if (rx_push) begin
         if (push_n < 64) push_log[push_n] = rx_data;
         push_n = push_n + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_start(input int kind, input int n, input logic [4:0] a, input logic [4:0] ta);
      push_n     = 0;
      cmd_kind   = 2'(kind);
      exp_words  = 6'(n);
      rt_addr    = a;
      tx_rt_addr = ta;
      start      = 1'b1;
      @(posedge clk); #1;
      start      = 1'b0;
   endtask

   task automatic send(input logic cmd, input logic enc, input logic par, input logic gp, input logic [15:0] d);
      wd_is_cmd = cmd; wd_enc_ok = enc; wd_par_ok = par; wd_gap = gp; wd_data = d;
      wd_valid  = 1'b1;
      @(posedge clk); #1;
      wd_valid  = 1'b0; wd_enc_ok = 1'b1; wd_par_ok = 1'b1; wd_gap = 1'b0;
   endtask

   task automatic pulse_timeout();
      resp_timeout = 1'b1;
      @(posedge clk); #1;
      resp_timeout = 1'b0;
   endtask

   function automatic string tag_of(input int f);
      case (f)
         1, 2, 3, 5: return "R5";
         4:          return "R6";
         6:          return "R7";
         7:          return "R8";
         default:    return "R3";
      endcase
   endfunction

   initial begin
      #(10 * 200000);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 valid", int'(msg_valid), 0);
      chk("R1 error", int'(msg_error), 0);
      chk("R1 err_bits", int'(err_bits), 0);
      chk("R1 stat1", int'(stat1), 0);
      chk("R1 busy", int'(busy), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R10 word while idle is ignored
      send(1'b0, 1'b0, 1'b1, 1'b0, 16'h1234);
      @(posedge clk); #1;
      chk("R10 idle valid", int'(msg_valid), 0);
      chk("R10 idle error", int'(msg_error), 0);
      chk("R10 idle err_bits", int'(err_bits), 0);
      chk("R10 idle push", push_n, 0);

      for (int r = 0; r < NV; r++) begin
         logic [23:0] v;
         int kind, n, f, fp, ee, total, dcount, exp_push, bad;
         logic [4:0] a_rx, a_tx;
         bit stopped;
         string tg;
         v    = VEC[r];
         kind = int'(v[23:22]); n = int'(v[21:16]); f = int'(v[15:13]);
         fp   = int'(v[12:7]);  ee = int'(v[6:0]);
         a_rx = 5'(r + 3); a_tx = 5'(r + 17);
         total  = (kind == 0) ? 1 : ((kind == 1) ? n + 1 : n + 2);
         dcount = (kind == 0) ? 0 : n;
         tg     = $sformatf("%s row%0d", tag_of(f), r);
         do_start(kind, n, a_rx, a_tx);
         chk($sformatf("R2 busy row%0d", r), int'(busy), 1);
         stopped = 1'b0;
         for (int i = 0; i < total && !stopped; i++) begin
            logic is_stat, cmd, enc, par, gp;
            logic [4:0] a;
            logic [15:0] dat;
            is_stat = (i == 0) || (kind == 2 && i == n + 1);
            a   = (kind == 2 && i == 0) ? a_tx : a_rx;
            dat = is_stat ? {a, 11'(r)} : {8'(r), 8'(i)};
            cmd = is_stat; enc = 1'b1; par = 1'b1; gp = 1'b0;
            if (i == fp) begin
               case (f)
                  1: cmd = !cmd;
                  2: enc = 1'b0;
                  3: par = 1'b0;
                  4: dat[15:11] = a + 5'd1;
                  5: gp = 1'b1;
                  6: begin pulse_timeout(); stopped = 1'b1; end
                  default: ;
               endcase
            end
            if (!stopped) send(cmd, enc, par, gp, dat);
            if (i == fp && f >= 1 && f <= 5) stopped = 1'b1;
         end
         if (f == 7) begin
            repeat (2) @(posedge clk); #1;
            send(1'b0, 1'b1, 1'b1, 1'b0, 16'hEEEE);
         end
         repeat (Q + 3) @(posedge clk); #1;
         exp_push = (f == 0 || f == 7) ? dcount :
                    ((fp == 0) ? 0 : ((fp - 1 < dcount) ? fp - 1 : dcount));
         chk({tg, " valid"}, int'(msg_valid), (ee == 0) ? 1 : 0);
         chk({tg, " error"}, int'(msg_error), (ee != 0) ? 1 : 0);
         chk({tg, " err_bits"}, int'(err_bits), ee);
         chk($sformatf("R4 row%0d push count", r), push_n, exp_push);
         bad = 0;
         for (int k = 0; k < exp_push && k < push_n && k < 64; k++) begin
            if (push_log[k] != {8'(r), 8'(k + 1)}) bad++;
         end
         chk($sformatf("R4 row%0d push data", r), bad, 0);
         if (ee == 0) begin
            chk($sformatf("R3 row%0d stat1", r), int'(stat1), int'({a_rx, 11'(r)}));
            if (kind == 2)
               chk($sformatf("R3 row%0d stat2", r), int'(stat2), int'({a_tx, 11'(r)}));
         end
      end

      // R8 exact quiet window timing
      do_start(1, 1, 5'd9, 5'd0);
      send(1'b1, 1'b1, 1'b1, 1'b0, {5'd9, 11'h055});
      send(1'b0, 1'b1, 1'b1, 1'b0, 16'hBEEF);
      repeat (Q - 1) @(posedge clk); #1;
      chk("R8 not yet valid", int'(msg_valid), 0);
      chk("R8 busy in window", int'(busy), 1);
      @(posedge clk); #1;
      chk("R8 valid on time", int'(msg_valid), 1);
      chk("R2 one outcome", int'(msg_error), 0);

      // R9 late word after valid
      send(1'b0, 1'b1, 1'b1, 1'b0, 16'h0F0F);
      chk("R9 valid cleared", int'(msg_valid), 0);
      chk("R9 error set", int'(msg_error), 1);
      chk("R9 err_bits", int'(err_bits), 7'h10);
      chk("R9 no push", push_n, 1);

      // R10 words after error ignored
      send(1'b1, 1'b0, 1'b0, 1'b1, {5'd1, 11'h0});
      @(posedge clk); #1;
      chk("R10 err_bits held", int'(err_bits), 7'h10);
      chk("R10 stat1 held", int'(stat1), int'({5'd9, 11'h055}));
      chk("R10 push held", push_n, 1);

      // R2 start clears the outcome
      do_start(1, 2, 5'd4, 5'd0);
      chk("R2 start clears error", int'(msg_error), 0);
      chk("R2 start clears err_bits", int'(err_bits), 0);

      // R5 several causes in one word
      send(1'b1, 1'b0, 1'b0, 1'b0, {5'd4, 11'h0});
      @(posedge clk); #1;
      chk("R5 multi cause", int'(err_bits), 7'h0C);
      chk("R5 multi error", int'(msg_error), 1);
      chk("R3 stat1 not captured", int'(stat1), int'({5'd9, 11'h055}));

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule